// File: doc/BRIEF.md
# Audio Subframe Formatter

This block sits between a transmit sample FIFO and a biphase line coder in a digital audio transmitter. Each time the line coder asks for the next subframe, the formatter takes a word from the FIFO and turns it into a 28-bit subframe body. The body is the part of the subframe that follows the 4-bit sync slot. It also returns a sync (preamble) code that tells the coder which pattern to send. Subframes are issued in left/right pairs. One pair is one frame, and a fixed number of frames forms a channel-status block.

Five word formats are supported. Plain 16-, 20- and 24-bit samples are right-aligned in the FIFO word, one word per subframe. A packed 16-bit mode carries both channels in one word. In raw mode the FIFO word already holds the complete subframe, including its validity, user, status and parity bits and a sync code, and it is passed through unchanged. In the non-raw modes the block inserts the validity, user and channel-status bits and generates even parity. If the FIFO is empty when a word is needed, the frame timing is kept: a muted subframe marked invalid is sent and flagged as an underrun. A busy flag marks the active period of the transmitter. It only ends at a frame boundary.

Top module: `subframe_formatter`

## Requirements
- R1: After a synchronous reset, `sf_valid`, `sf_payload`, `sf_pre`, `sf_left`, `sf_underrun` and `tx_busy` are all 0, and `fifo_rd` stays low while no request is served.
- R2: `tx_busy` rises on the clock edge after `tx_enable` is seen high. A request made while the block is idle gives no `sf_valid` and no FIFO read. A served request gives `sf_valid` for exactly one cycle, on the edge that samples the request.
- R3: When `tx_enable` is cleared in the middle of a frame, `tx_busy` stays high. The pending right subframe is still served. `tx_busy` falls on the next edge after that subframe.
- R4: At start, `first_left`=1 makes the first subframe a left one (`sf_left`=1) and `first_left`=0 makes it a right one. After that, subframes alternate between left and right.
- R5: Width mode 00/01/10 selects 16/20/24-bit samples taken from bit 0 of the word. The sample is placed MSB-first into `sf_payload[23:0]` with zeros below it. Upper word bits that are not used are ignored.
- R6: Width mode 11 (raw): `sf_payload` = word[31:4] and `sf_pre` = word[3:0], unchanged.
- R7: With pack enabled in 16-bit mode, a left subframe reads one word and uses bits 15:0. The following right subframe uses bits 31:16 of the same word without a second read. With any other width mode, pack has no effect.
- R8: In non-raw modes, `sf_payload[24]`=0 (valid), `[25]`=`user_bit`, `[26]`=`cs_bit`, and `[27]` makes the 28 payload bits hold an even number of ones.
- R9: If the FIFO is empty when a word is needed, no read is made. The subframe carries `sf_underrun`=1, `[23:0]`=0, `[24]`=1 and even parity.
- R10: Sync codes in non-raw modes are 0001 for the left subframe of the first frame of each block of `FRAMES_PER_BLOCK` frames, 0010 for other left subframes and 0100 for right subframes. When the stream starts with a right subframe, the next left subframe opens a block.
- R11: `fifo_rd` is high only in a cycle where a request is being served, and at most once per subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmitter enable |
| first_left | input | 1 | Channel of the first subframe after start: 1 left, 0 right |
| width_mode | input | 2 | 00 16-bit, 01 20-bit, 10 24-bit, 11 raw |
| pack_en | input | 1 | Two 16-bit samples per FIFO word (16-bit mode only) |
| cs_bit | input | 1 | Channel-status bit for the next non-raw subframe |
| user_bit | input | 1 | User bit for the next non-raw subframe |
| fifo_empty | input | 1 | Transmit FIFO has no word |
| fifo_rdata | input | 32 | Head word of the transmit FIFO (first-word fall-through) |
| fifo_rd | output | 1 | Pop the head word |
| sf_req | input | 1 | Line coder asks for the next subframe |
| sf_valid | output | 1 | Subframe outputs updated this cycle |
| sf_payload | output | 28 | Subframe bits after the sync slot, aux/audio LSB first at [0] |
| sf_pre | output | 4 | Sync code |
| sf_left | output | 1 | Subframe belongs to the left channel |
| sf_underrun | output | 1 | Subframe was filled because the FIFO was empty |
| tx_busy | output | 1 | Transmitter active |

## Verification
The assertions check on every cycle that outputs appear only for a served request, that non-raw and underrun subframes carry even parity, that an underrun subframe is muted and marked invalid, that busy only drops at a frame boundary after the enable goes away, and that a packed half is held only after a left-side read. Only the bench scenarios can show that the sample lands in the right bit positions for each width, that raw words pass through bit for bit, that the block-start sync code returns after exactly one block, and that the choice of start channel changes the order of subframes.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  typedef enum logic [1:0] {
    WM_16  = 2'b00,
    WM_20  = 2'b01,
    WM_24  = 2'b10,
    WM_RAW = 2'b11
  } width_mode_t;

  localparam int WORD_W    = 32;
  localparam int BODY_W    = 28;
  localparam int AUDIO_W   = 24;
  localparam int HALF_W    = WORD_W / 2;

  localparam logic [3:0] PRE_BLOCK = 4'b0001;
  localparam logic [3:0] PRE_LEFT  = 4'b0010;
  localparam logic [3:0] PRE_RIGHT = 4'b0100;
endpackage

// File: rtl/sfmt_sequencer.sv
module sfmt_sequencer #(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_enable,
  input  logic first_left,
  input  logic sf_req,
  output logic busy,
  output logic take,
  output logic next_left,
  output logic block_first
);
  localparam int CNT_W = (FRAMES_PER_BLOCK > 1) ? $clog2(FRAMES_PER_BLOCK) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES_PER_BLOCK - 1);

  logic [CNT_W-1:0] frame_cnt;

  // a new frame is not opened once the enable has gone
  assign take        = sf_req && busy && (tx_enable || !next_left);
  assign block_first = (frame_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      next_left <= 1'b0;
      frame_cnt <= '0;
    end else if (!busy) begin
      if (tx_enable) begin
        busy      <= 1'b1;
        next_left <= first_left;
        frame_cnt <= first_left ? '0 : LAST;
      end
    end else if (take) begin
      next_left <= !next_left;
      if (!next_left)
        frame_cnt <= (frame_cnt == LAST) ? '0 : frame_cnt + 1'b1;
    end else if (!tx_enable && next_left) begin
      busy <= 1'b0;
    end
  end

  assert_busy_frame_end_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!$past(tx_enable) && $past(next_left)));

  assert_alternate_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(take) && busy && $past(busy)) |-> (next_left != $past(next_left)));
endmodule

// File: rtl/sfmt_source.sv
module sfmt_source
  import sfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              take,
  input  logic              is_left,
  input  logic              pack_active,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  output logic              underrun,
  output logic [WORD_W-1:0] word
);
  logic              hold_valid;
  logic [HALF_W-1:0] hold_half;
  logic              use_hold;

  assign use_hold = pack_active && !is_left && hold_valid;
  assign fifo_rd  = take && !use_hold && !fifo_empty;
  assign underrun = take && !use_hold && fifo_empty;

  always_comb begin
    if (use_hold)
      word = {{HALF_W{1'b0}}, hold_half};
    else if (pack_active)
      word = {{HALF_W{1'b0}}, is_left ? fifo_rdata[HALF_W-1:0] : fifo_rdata[WORD_W-1:HALF_W]};
    else
      word = fifo_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !pack_active)
      hold_valid <= 1'b0;
    else if (take)
      hold_valid <= fifo_rd && is_left;
  end

  always_ff @(posedge clk) begin
    if (take && fifo_rd && is_left)
      hold_half <= fifo_rdata[WORD_W-1:HALF_W];
  end

  assert_hold_after_left_read_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_valid) |-> $past(fifo_rd && is_left && pack_active));
endmodule

// File: rtl/sfmt_format.sv
module sfmt_format
  import sfmt_pkg::*;
(
  input  logic [1:0]        width_mode,
  input  logic [WORD_W-1:0] word,
  input  logic              underrun,
  input  logic              cs_bit,
  input  logic              user_bit,
  input  logic              is_left,
  input  logic              block_first,
  output logic [BODY_W-1:0] payload,
  output logic [3:0]        pre
);
  width_mode_t        wm;
  logic [AUDIO_W-1:0] audio;
  logic [BODY_W-2:0]  body;

  assign wm = width_mode_t'(width_mode);

  always_comb begin
    case (wm)
      WM_16:   audio = {word[15:0], 8'h00};
      WM_20:   audio = {word[19:0], 4'h0};
      WM_24:   audio = word[23:0];
      default: audio = '0;
    endcase
    body = {cs_bit, user_bit, underrun, underrun ? {AUDIO_W{1'b0}} : audio};
    if (wm == WM_RAW && !underrun) begin
      payload = word[WORD_W-1:4];
      pre     = word[3:0];
    end else begin
      payload = {^body, body};
      pre     = is_left ? (block_first ? PRE_BLOCK : PRE_LEFT) : PRE_RIGHT;
    end
  end
endmodule

// File: rtl/subframe_formatter.sv
module subframe_formatter
  import sfmt_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_enable,
  input  logic        first_left,
  input  logic [1:0]  width_mode,
  input  logic        pack_en,
  input  logic        cs_bit,
  input  logic        user_bit,
  input  logic        fifo_empty,
  input  logic [31:0] fifo_rdata,
  output logic        fifo_rd,
  input  logic        sf_req,
  output logic        sf_valid,
  output logic [27:0] sf_payload,
  output logic [3:0]  sf_pre,
  output logic        sf_left,
  output logic        sf_underrun,
  output logic        tx_busy
);
  logic              busy, take, next_left, block_first;
  logic              src_underrun, pack_active;
  logic [WORD_W-1:0] src_word;
  logic [BODY_W-1:0] fmt_payload;
  logic [3:0]        fmt_pre;

  assign pack_active = pack_en && (width_mode == WM_16);
  assign tx_busy     = busy;

  sfmt_sequencer #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)) u_seq (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .first_left(first_left),
    .sf_req(sf_req), .busy(busy), .take(take), .next_left(next_left),
    .block_first(block_first)
  );

  sfmt_source u_src (
    .clk(clk), .rst(rst), .restart(!busy), .take(take), .is_left(next_left),
    .pack_active(pack_active), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .fifo_rd(fifo_rd), .underrun(src_underrun), .word(src_word)
  );

  sfmt_format u_fmt (
    .width_mode(width_mode), .word(src_word), .underrun(src_underrun),
    .cs_bit(cs_bit), .user_bit(user_bit), .is_left(next_left),
    .block_first(block_first), .payload(fmt_payload), .pre(fmt_pre)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sf_valid    <= 1'b0;
      sf_payload  <= '0;
      sf_pre      <= '0;
      sf_left     <= 1'b0;
      sf_underrun <= 1'b0;
    end else begin
      sf_valid <= take;
      if (take) begin
        sf_payload  <= fmt_payload;
        sf_pre      <= fmt_pre;
        sf_left     <= next_left;
        sf_underrun <= src_underrun;
      end
    end
  end

  assert_valid_from_req_R2: assert property (@(posedge clk) disable iff (rst)
    sf_valid |-> ($past(sf_req) && $past(tx_busy)));

  assert_even_parity_R8: assert property (@(posedge clk) disable iff (rst)
    (sf_valid && (sf_underrun || $past(width_mode) != WM_RAW)) |-> (^sf_payload == 1'b0));

  assert_underrun_muted_R9: assert property (@(posedge clk) disable iff (rst)
    (sf_valid && sf_underrun) |-> (sf_payload[24] && sf_payload[23:0] == '0));

  assert_read_in_service_R11: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (sf_req && tx_busy && !fifo_empty));
endmodule

// File: tb/subframe_formatter_test.sv
`timescale 1ns/1ps
module subframe_formatter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_enable = 1'b0, first_left = 1'b1, pack_en = 1'b0;
  logic        cs_bit = 1'b0, user_bit = 1'b0, sf_req = 1'b0;
  logic [1:0]  width_mode = 2'b00;
  logic        fifo_empty, fifo_rd;
  logic [31:0] fifo_rdata;
  logic        sf_valid, sf_left, sf_underrun, tx_busy;
  logic [27:0] sf_payload;
  logic [3:0]  sf_pre;

  logic [31:0] q [64];
  logic [5:0]  wr_ptr = '0, rd_ptr = '0;
  int          rd_cnt = 0;
  int          checks = 0, errors = 0;

  assign fifo_empty = (wr_ptr == rd_ptr);
  assign fifo_rdata = q[rd_ptr];

  always #2.5 clk = !clk;

  always @(posedge clk) if (!rst && fifo_rd) begin
    rd_ptr <= rd_ptr + 1'b1;
    rd_cnt <= rd_cnt + 1;
  end

  subframe_formatter uut (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .first_left(first_left),
    .width_mode(width_mode), .pack_en(pack_en), .cs_bit(cs_bit), .user_bit(user_bit),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
    .sf_req(sf_req), .sf_valid(sf_valid), .sf_payload(sf_payload), .sf_pre(sf_pre),
    .sf_left(sf_left), .sf_underrun(sf_underrun), .tx_busy(tx_busy)
  );

  // {mode, word, expected body (parity bit left 0 for non-raw), expected raw sync}
  localparam logic [65:0] VEC [7] = '{
    {2'b00, 32'h0000_ABCD, 28'h0ABCD00, 4'h0},
    {2'b00, 32'hFFFF_1234, 28'h0123400, 4'h0},
    {2'b01, 32'h000F_EDCB, 28'h0FEDCB0, 4'h0},
    {2'b10, 32'h00A5_5A3C, 28'h0A55A3C, 4'h0},
    {2'b10, 32'hFF80_0001, 28'h0800001, 4'h0},
    {2'b11, 32'hD123_4567, 28'hD123456, 4'h7},
    {2'b11, 32'h0000_000F, 28'h0000000, 4'hF}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] with_par(input logic [27:0] e);
    logic [27:0] r;
    r = e;
    r[27] = ^e[26:0];
    return r;
  endfunction

  task automatic push(input logic [31:0] w);
    q[wr_ptr] = w;
    wr_ptr = wr_ptr + 1'b1;
  endtask

  task automatic req();
    @(negedge clk);
    sf_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sf_req = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    int bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sf_valid == 0 && sf_payload == 0 && sf_pre == 0 && !sf_left && !sf_underrun && !tx_busy,
          "R1 reset outputs", {sf_valid, sf_left, sf_underrun, tx_busy, sf_payload}, 32'h0);

    // R2 request while idle
    push(32'h0000_5555);
    req();
    check(!sf_valid && rd_cnt == 0, "R2 idle request ignored", {sf_valid, 31'(rd_cnt)}, 32'h0);
    rd_ptr = wr_ptr;

    tx_enable = 1'b1; first_left = 1'b1;
    @(posedge clk); @(negedge clk);
    check(tx_busy, "R2 busy after enable", 32'(tx_busy), 32'h1);

    // table walk: R5 R6 R8
    for (int i = 0; i < 7; i++) begin
      logic [1:0]  m;
      logic [31:0] w;
      logic [27:0] e;
      logic [3:0]  p;
      {m, w, e, p} = VEC[i];
      width_mode = m;
      push(w);
      r0 = rd_cnt;
      req();
      if (m != 2'b11) e = with_par(e);
      check(sf_valid && sf_payload == e, (m == 2'b11) ? "R6 raw body" : "R5 sample body", 32'(sf_payload), 32'(e));
      check(rd_cnt == r0 + 1 && !sf_underrun, "R11 one read per subframe", 32'(rd_cnt - r0), 32'h1);
      if (m == 2'b11) check(sf_pre == p, "R6 raw sync", 32'(sf_pre), 32'(p));
      if (i == 0) check(sf_left && sf_pre == 4'b0001, "R4 R10 first left block start", {sf_left, sf_pre}, {1'b1, 4'b0001});
      if (i == 1) check(!sf_left, "R4 alternation", 32'(sf_left), 32'h0);
    end

    // R8 status and user bits, right subframe
    width_mode = 2'b10; cs_bit = 1'b1; user_bit = 1'b1;
    push(32'h0000_0001);
    req();
    check(sf_payload == 28'hE000001, "R8 cs/user/parity", 32'(sf_payload), 32'hE000001);
    check(sf_pre == 4'b0100 && !sf_left, "R10 right sync", 32'(sf_pre), 32'h4);
    cs_bit = 1'b0; user_bit = 1'b0;

    // R9 underrun
    width_mode = 2'b00;
    r0 = rd_cnt;
    req();
    check(sf_underrun && sf_payload == 28'h9000000, "R9 underrun body", {sf_underrun, 3'b0, sf_payload}, 32'h19000000);
    check(rd_cnt == r0, "R9 no read when empty", 32'(rd_cnt), 32'(r0));
    check(sf_pre == 4'b0010, "R10 left sync mid block", 32'(sf_pre), 32'h2);
    req();

    // R10 block wrap: frames 5..191 then block start
    bad = 0;
    for (int f = 5; f < 192; f++) begin
      req();
      if (sf_pre != 4'b0010) bad++;
      req();
      if (sf_pre != 4'b0100) bad++;
    end
    check(bad == 0, "R10 sync codes within block", 32'(bad), 32'h0);
    req();
    check(sf_left && sf_pre == 4'b0001, "R10 block start after wrap", 32'(sf_pre), 32'h1);
    req();

    // R7 packed 16-bit
    pack_en = 1'b1; width_mode = 2'b00;
    push(32'h1111_2222); push(32'h3333_4444);
    r0 = rd_cnt;
    req(); check(sf_payload == with_par(28'h0222200), "R7 packed left low half", 32'(sf_payload), 32'(with_par(28'h0222200)));
    req(); check(sf_payload == with_par(28'h0111100), "R7 packed right high half", 32'(sf_payload), 32'(with_par(28'h0111100)));
    check(rd_cnt == r0 + 1, "R7 one read per pair", 32'(rd_cnt - r0), 32'h1);
    req(); check(sf_payload == with_par(28'h0444400), "R7 packed left word 2", 32'(sf_payload), 32'(with_par(28'h0444400)));
    req(); check(sf_payload == with_par(28'h0333300), "R7 packed right word 2", 32'(sf_payload), 32'(with_par(28'h0333300)));

    // R7 pack ignored at 24-bit
    width_mode = 2'b10;
    push(32'h0011_2233); push(32'h0044_5566);
    r0 = rd_cnt;
    req(); check(sf_payload == with_par(28'h0112233), "R7 pack ignored left", 32'(sf_payload), 32'(with_par(28'h0112233)));
    req(); check(sf_payload == with_par(28'h0445566), "R7 pack ignored right", 32'(sf_payload), 32'(with_par(28'h0445566)));
    check(rd_cnt == r0 + 2, "R7 two reads when not packed", 32'(rd_cnt - r0), 32'h2);
    pack_en = 1'b0;

    // R3 stop mid frame
    req();
    tx_enable = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_busy, "R3 busy held mid frame", 32'(tx_busy), 32'h1);
    req();
    check(sf_valid && !sf_left, "R3 right subframe served", {sf_valid, sf_left}, 32'h2);
    check(tx_busy, "R3 busy through last subframe", 32'(tx_busy), 32'h1);
    @(negedge clk);
    check(!tx_busy, "R3 busy falls at frame end", 32'(tx_busy), 32'h0);
    req();
    check(!sf_valid, "R2 no service after stop", 32'(sf_valid), 32'h0);

    // R4 start on right
    first_left = 1'b0; tx_enable = 1'b1; width_mode = 2'b00;
    @(posedge clk); @(negedge clk);
    req();
    check(!sf_left && sf_pre == 4'b0100, "R4 first subframe right", {sf_left, sf_pre}, {1'b0, 4'b0100});
    req();
    check(sf_left && sf_pre == 4'b0001, "R10 block opens after right start", {sf_left, sf_pre}, {1'b1, 4'b0001});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule